// File: doc/BRIEF.md
# Over-clock Sweep Response Builder

This block runs a stepped clock-frequency sweep and assembles a device-unique response string from it. A frequency is an unsigned integer code in which one unit is half a megahertz. After a start strobe, the block walks the clock away from its nominal setting and toward the lower edge of an enrollment window. It moves one code unit per request to an external clock generator and waits for that generator's lock acknowledge after each request. Once inside the window it visits every code from the lower edge to the upper edge in rising order. At each code it triggers an external quantizer and shifts the returned 2-bit code into a response register. It then walks the clock back to nominal, again one unit at a time, and pulses done.

Before moving the clock, the block validates the configuration. The window must be ordered. The upper edge and the nominal setting must not lie above the safety ceiling. The window must fit in the response register. A rejected start raises the error flag, pulses done at once and issues no frequency request. The response is right-justified, the first sample lands in the most significant occupied pair, and the length output gives the number of valid bits.

Top module: `sweep_resp_builder`

## Requirements
- R1: While a sweep is in progress, every change of `freq_code` is exactly one code unit up or down, and each change comes with a new rising `freq_req`.
- R2: `freq_code` never exceeds the ceiling captured at start while `freq_req` is high.
- R3: Once raised, `freq_req` stays high with `freq_code` unchanged until `freq_ack` is seen high. `freq_req` drops on the edge that samples the acknowledge.
- R4: `q_go` is a one-cycle pulse issued only after the acknowledge of the requested code, with no request pending, and only at codes inside the window. There is exactly one pulse per window code.
- R5: The response holds the 2-bit quantizer codes of the window, in rising frequency order. The code from the lower edge sits in the most significant occupied pair, and the code from the upper edge sits in bits [1:0].
- R6: `resp_len` equals 2 × (upper − lower + 1). A window whose edges are equal yields one point and a length of 2.
- R7: A window with more than RMAX/2 points is rejected. `err` goes to 1, `resp_len` is 0, and no request is made. A window of exactly RMAX/2 points is accepted and fills the register.
- R8: A start whose upper edge or nominal setting lies above the ceiling is rejected in the same way. An upper edge equal to the ceiling is accepted.
- R9: A start whose lower edge lies above its upper edge is rejected in the same way.
- R10: After the last window point the clock returns to nominal one unit at a time, and `done` is raised only with `freq_code` equal to the nominal code.
- R11: A start strobe seen while `busy` is high is ignored, together with the input values presented with it.
- R12: `busy` is high from an accepted start until the cycle of `done`. `done` is a one-cycle pulse, and `err` is cleared by the next accepted start.
- R13: The entry walk goes toward the lower edge in either direction, so a nominal setting above the window is first stepped down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, taken only when idle |
| f_home | input | FW | Nominal frequency code, the current clock at start |
| win_lo | input | FW | Lower window edge code |
| win_hi | input | FW | Upper window edge code |
| f_ceiling | input | FW | Safety ceiling code |
| freq_req | output | 1 | Frequency change request to the clock generator |
| freq_code | output | FW | Requested or current frequency code |
| freq_ack | input | 1 | Clock generator lock acknowledge |
| q_go | output | 1 | One-cycle quantizer trigger |
| q_done | input | 1 | Quantizer result valid |
| q_code | input | 2 | Quantizer 2-bit result |
| resp | output | RMAX | Response string, right-justified |
| resp_len | output | LW | Number of valid response bits |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end pulse, for both a finished and a rejected start |
| err | output | 1 | Last start was rejected |

## Verification
The bench builds the block with an 8-bit frequency code and the full 128-bit response register. With these settings a 64-point window that exactly fills the register and a 65-point window that overflows it both fit inside the code range. This brings the capacity boundary of R7 within reach, alongside short windows, a single-point window at the ceiling and a nominal setting above the window. The clock generator model varies its acknowledge latency with the code, so the handshake is exercised with different waits.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MOVE,
    ST_ACK,
    ST_TRIG,
    ST_WAITQ
  } sweep_st_t;

  typedef enum logic [1:0] {
    PH_ENTRY,
    PH_WIN,
    PH_HOME
  } sweep_ph_t;
endpackage

// File: rtl/sweep_window_check.sv
module sweep_window_check #(
  parameter int FW   = 10,
  parameter int RMAX = 128
) (
  input  logic [FW-1:0] lo,
  input  logic [FW-1:0] hi,
  input  logic [FW-1:0] home,
  input  logic [FW-1:0] ceil_code,
  output logic          order_bad,
  output logic          ceil_bad,
  output logic          cap_bad,
  output logic          bad
);
  localparam logic [FW:0] MAXP = (FW+1)'(RMAX / 2);

  function automatic logic [FW:0] span_points(input logic [FW-1:0] a, input logic [FW-1:0] b);
    return {1'b0, b} - {1'b0, a} + (FW+1)'(1);
  endfunction

  logic [FW:0] pts;

  always_comb begin
    pts       = span_points(lo, hi);
    order_bad = lo > hi;
    ceil_bad  = (hi > ceil_code) || (home > ceil_code);
    cap_bad   = !order_bad && (pts > MAXP);
    bad       = order_bad || ceil_bad || cap_bad;
  end
endmodule

// File: rtl/sweep_response_reg.sv
module sweep_response_reg #(
  parameter int RMAX = 128,
  parameter int LW   = $clog2(RMAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            shift,
  input  logic [1:0]      code,
  output logic [RMAX-1:0] resp,
  output logic [LW-1:0]   resp_len
);
  function automatic logic [RMAX-1:0] push_pair(input logic [RMAX-1:0] r, input logic [1:0] c);
    return {r[RMAX-3:0], c};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp     <= '0;
      resp_len <= '0;
    end else if (clr) begin
      resp     <= '0;
      resp_len <= '0;
    end else if (shift) begin
      resp     <= push_pair(resp, code);
      resp_len <= resp_len + LW'(2);
    end
  end
endmodule

// File: rtl/sweep_step_fsm.sv
module sweep_step_fsm
  import sweep_pkg::*;
#(
  parameter int FW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cfg_bad,
  input  logic [FW-1:0] in_lo,
  input  logic [FW-1:0] in_hi,
  input  logic [FW-1:0] in_home,
  input  logic [FW-1:0] in_ceil,
  input  logic          freq_ack,
  input  logic          q_done,
  output logic          freq_req,
  output logic [FW-1:0] cur,
  output logic          q_go,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          clr,
  output logic          shift,
  output logic [FW-1:0] cfg_lo,
  output logic [FW-1:0] cfg_hi,
  output logic [FW-1:0] cfg_home,
  output logic [FW-1:0] cfg_ceil
);
  sweep_st_t st;
  sweep_ph_t ph;
  logic [FW-1:0] tgt;

  function automatic logic [FW-1:0] step_toward(input logic [FW-1:0] c, input logic [FW-1:0] t);
    return (c < t) ? c + FW'(1) : c - FW'(1);
  endfunction

  assign tgt   = (ph == PH_ENTRY) ? cfg_lo : cfg_home;
  assign clr   = (st == ST_IDLE) && start;
  assign shift = (st == ST_WAITQ) && q_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= PH_ENTRY;
      cur      <= '0;
      freq_req <= 1'b0;
      q_go     <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      cfg_lo   <= '0;
      cfg_hi   <= '0;
      cfg_home <= '0;
      cfg_ceil <= '0;
    end else begin
      done <= 1'b0;
      q_go <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            cur      <= in_home;
            cfg_lo   <= in_lo;
            cfg_hi   <= in_hi;
            cfg_home <= in_home;
            cfg_ceil <= in_ceil;
            err      <= cfg_bad;
            ph       <= PH_ENTRY;
            if (cfg_bad) begin
              done <= 1'b1;
            end else begin
              busy <= 1'b1;
              st   <= ST_MOVE;
            end
          end
        end
        ST_MOVE: begin
          if (cur == tgt) begin
            if (ph == PH_ENTRY) begin
              ph <= PH_WIN;
              st <= ST_TRIG;
            end else begin
              busy <= 1'b0;
              done <= 1'b1;
              st   <= ST_IDLE;
            end
          end else begin
            cur      <= step_toward(cur, tgt);
            freq_req <= 1'b1;
            st       <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (freq_ack) begin
            freq_req <= 1'b0;
            st       <= (ph == PH_WIN) ? ST_TRIG : ST_MOVE;
          end
        end
        ST_TRIG: begin
          q_go <= 1'b1;
          st   <= ST_WAITQ;
        end
        ST_WAITQ: begin
          if (q_done) begin
            if (cur == cfg_hi) begin
              ph <= PH_HOME;
              st <= ST_MOVE;
            end else begin
              cur      <= cur + FW'(1);
              freq_req <= 1'b1;
              st       <= ST_ACK;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sweep_resp_builder.sv
module sweep_resp_builder #(
  parameter int FW   = 10,
  parameter int RMAX = 128,
  parameter int LW   = $clog2(RMAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [FW-1:0]   f_home,
  input  logic [FW-1:0]   win_lo,
  input  logic [FW-1:0]   win_hi,
  input  logic [FW-1:0]   f_ceiling,
  output logic            freq_req,
  output logic [FW-1:0]   freq_code,
  input  logic            freq_ack,
  output logic            q_go,
  input  logic            q_done,
  input  logic [1:0]      q_code,
  output logic [RMAX-1:0] resp,
  output logic [LW-1:0]   resp_len,
  output logic            busy,
  output logic            done,
  output logic            err
);
  logic          order_bad, ceil_bad, cap_bad, cfg_bad;
  logic          ev_clr, ev_shift;
  logic [FW-1:0] cfg_lo, cfg_hi, cfg_home, cfg_ceil;

  sweep_window_check #(.FW(FW), .RMAX(RMAX)) u_check (
    .lo        (win_lo),
    .hi        (win_hi),
    .home      (f_home),
    .ceil_code (f_ceiling),
    .order_bad (order_bad),
    .ceil_bad  (ceil_bad),
    .cap_bad   (cap_bad),
    .bad       (cfg_bad)
  );

  sweep_step_fsm #(.FW(FW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cfg_bad  (cfg_bad),
    .in_lo    (win_lo),
    .in_hi    (win_hi),
    .in_home  (f_home),
    .in_ceil  (f_ceiling),
    .freq_ack (freq_ack),
    .q_done   (q_done),
    .freq_req (freq_req),
    .cur      (freq_code),
    .q_go     (q_go),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .clr      (ev_clr),
    .shift    (ev_shift),
    .cfg_lo   (cfg_lo),
    .cfg_hi   (cfg_hi),
    .cfg_home (cfg_home),
    .cfg_ceil (cfg_ceil)
  );

  sweep_response_reg #(.RMAX(RMAX), .LW(LW)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ev_clr),
    .shift    (ev_shift),
    .code     (q_code),
    .resp     (resp),
    .resp_len (resp_len)
  );
endmodule

// File: rtl/sweep_resp_builder_chk.sv
module sweep_resp_builder_chk #(
  parameter int FW   = 10,
  parameter int RMAX = 128,
  parameter int LW   = $clog2(RMAX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          freq_req,
  input logic [FW-1:0] freq_code,
  input logic          freq_ack,
  input logic          q_go,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [LW-1:0] resp_len,
  input logic          ev_shift,
  input logic          order_bad,
  input logic          ceil_bad,
  input logic          cap_bad,
  input logic [FW-1:0] cfg_lo,
  input logic [FW-1:0] cfg_hi,
  input logic [FW-1:0] cfg_home,
  input logic [FW-1:0] cfg_ceil
);
  p_unit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (freq_code != $past(freq_code))) |->
      ($rose(freq_req) && ((freq_code == $past(freq_code) + FW'(1)) ||
                           (freq_code + FW'(1) == $past(freq_code)))));

  p_ceiling_r2: assert property (@(posedge clk) disable iff (!rst_n)
    freq_req |-> (freq_code <= cfg_ceil));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_req && !freq_ack) |=> (freq_req && $stable(freq_code)));

  p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_req && freq_ack) |=> !freq_req);

  p_sample_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    q_go |-> (!freq_req && (freq_code >= cfg_lo) && (freq_code <= cfg_hi)));

  p_go_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    q_go |=> !q_go);

  p_len_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_shift |-> (resp_len < LW'(RMAX)));

  p_reject_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (resp_len == '0));

  p_home_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((freq_code == cfg_home) && !busy));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_req_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!freq_req && !q_go));

  p_flags_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({order_bad, cap_bad}) || ceil_bad);
endmodule

bind sweep_resp_builder sweep_resp_builder_chk #(.FW(FW), .RMAX(RMAX), .LW(LW)) u_chk (.*);

// File: tb/sweep_resp_builder_test.sv
module sweep_resp_builder_test;
  localparam int FW   = 8;
  localparam int RMAX = 128;
  localparam int LW   = 8;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            start = 0;
  logic [FW-1:0]   f_home = 0, win_lo = 0, win_hi = 0, f_ceiling = 0;
  logic            freq_req;
  logic [FW-1:0]   freq_code;
  logic            freq_ack = 0;
  logic            q_go;
  logic            q_done = 0;
  logic [1:0]      q_code = 0;
  logic [RMAX-1:0] resp;
  logic [LW-1:0]   resp_len;
  logic            busy, done, err;

  int tests = 0;
  int fails = 0;
  int go_count = 0;
  logic [FW-1:0] applied = 0;
  logic [FW-1:0] exp_f[$];
  logic [FW-1:0] cur_ceil = 0;

  always #5 clk = ~clk;

  sweep_resp_builder #(.FW(FW), .RMAX(RMAX), .LW(LW)) uut (.*);

  function automatic logic [1:0] qfun(input logic [FW-1:0] f);
    return 2'((f ^ (f >> 2) ^ (f >> 5)) & 8'd3);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [RMAX-1:0] act, input logic [RMAX-1:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  // clock generator model and frequency monitor (scoreboard side)
  initial begin
    forever begin
      @(posedge clk); #2;
      if (freq_req) begin
        repeat (1 + int'(freq_code % 3)) @(posedge clk);
        #1;
        applied = freq_code;
        if (exp_f.size() == 0) begin
          chk(0, "R1 R13", "unexpected frequency request", freq_code, 0);
        end else begin
          logic [FW-1:0] e;
          e = exp_f.pop_front();
          chk(freq_code == e, "R1 R3 R13", "requested code", freq_code, e);
        end
        chk(freq_code <= cur_ceil, "R2", "code under ceiling", freq_code, cur_ceil);
        freq_ack = 1;
        @(posedge clk); #1;
        freq_ack = 0;
      end
    end
  end

  // quantizer model
  initial begin
    forever begin
      @(posedge clk); #2;
      if (q_go) begin
        go_count++;
        chk(!freq_req && (applied == freq_code), "R4", "trigger after lock", freq_code, applied);
        repeat (2) @(posedge clk);
        #1;
        q_code = qfun(applied);
        q_done = 1;
        @(posedge clk); #1;
        q_done = 0;
      end
    end
  end

  task automatic wait_done(input string rq);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) chk(0, rq, "watchdog waiting for done", 0, 1);
  endtask

  task automatic run_sweep(input int home, input int lo, input int hi, input int ceil,
                           input bit exp_err, input bit poke, input string rq);
    logic [RMAX-1:0] er = 0;
    int npts;
    go_count = 0;
    applied  = FW'(home);
    cur_ceil = FW'(ceil);
    if (!exp_err) begin
      int c = home;
      while (c != lo) begin
        c = (c < lo) ? c + 1 : c - 1;
        exp_f.push_back(FW'(c));
      end
      for (int f = lo + 1; f <= hi; f++) exp_f.push_back(FW'(f));
      c = hi;
      while (c != home) begin
        c = (c < home) ? c + 1 : c - 1;
        exp_f.push_back(FW'(c));
      end
      for (int f = lo; f <= hi; f++) er = (er << 2) | RMAX'(qfun(FW'(f)));
      npts = hi - lo + 1;
    end else begin
      npts = 0;
    end
    f_home = FW'(home); win_lo = FW'(lo); win_hi = FW'(hi); f_ceiling = FW'(ceil);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (!exp_err) chk(busy == 1, "R12", "busy after accepted start", busy, 1);
    if (poke) begin
      repeat (7) @(negedge clk);
      win_lo = FW'(lo + 3); win_hi = FW'(hi + 5); f_home = FW'(home + 1);
      start = 1;
      @(negedge clk); start = 0;
      win_lo = FW'(lo); win_hi = FW'(hi); f_home = FW'(home);
    end
    wait_done(rq);
    chk(err == exp_err, rq, "error flag", err, exp_err);
    chk(resp_len == LW'(2 * npts), rq, "response length", resp_len, 2 * npts);
    chk(resp == er, rq, "response bits", resp, er);
    chk(freq_code == FW'(home), "R10", "back at nominal", freq_code, home);
    chk(exp_f.size() == 0, "R10", "all steps issued", exp_f.size(), 0);
    chk(go_count == npts, "R4", "trigger count", go_count, npts);
    @(negedge clk);
    chk(!done && !busy, "R12", "done single pulse, idle", {done, busy}, 0);
    exp_f.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1000000;
    chk(0, "R12", "global watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !freq_req && !q_go, "R12", "reset outputs",
        {busy, done, err, freq_req, q_go}, 0);
    chk(resp == 0 && resp_len == 0, "R5", "reset response", resp, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run_sweep(16, 20, 30, 40, 0, 0, "R5 R6");
    run_sweep(25, 25, 25, 25, 0, 0, "R6 R8");
    run_sweep(10, 10, 73, 80, 0, 0, "R7");
    run_sweep(10, 10, 74, 80, 1, 0, "R7");
    run_sweep(16, 20, 30, 29, 1, 0, "R8");
    run_sweep(50, 20, 30, 40, 1, 0, "R8");
    run_sweep(16, 30, 20, 40, 1, 0, "R9");
    run_sweep(50, 30, 35, 60, 0, 0, "R13 R12");
    run_sweep(16, 20, 30, 40, 0, 1, "R11");
    run_sweep(3, 4, 9, 9, 0, 0, "R5");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule